// File: doc/BRIEF.md
# Software Security Level Gate

This block keeps a one-byte software protection level for an on-chip programming agent and rules on every memory operation that agent wants to perform. A request names an operation kind (read, write, block erase, whole-array erase, blank check) and a target class (code array, fuse byte, protection byte, configuration byte, identification byte). The block answers one cycle later with a grant, or with a denial and a one-byte error code. The agent then carries out granted operations, or passes the error code to the host.

The protection level can only move toward stricter settings. A protection-byte write that would relax the level, keep it the same or use an unknown encoding is refused. Only a granted whole-array erase brings the level back to the open setting. The same erase restores the boot-status and boot-vector configuration bytes to their erased value. The configuration bytes live inside the block and stay writable at every level.

Top module: `sec_level_gate`

## Requirements
- R1: The level takes only the encodings FFh (open), FEh (write-protected) and FCh (fully protected). It is visible on `sec_level_o`. A protection-byte read (kind 0, class 2) is granted at every level and returns the level on `rsp_rdata`.
- R2: A protection-byte write (kind 1, class 2) is granted only when `req_wdata` is a legal encoding stricter than the current level (FFh to FEh or FCh, FEh to FCh). Any other value is denied with status 03h and leaves the level unchanged. This covers equal, relaxing and unknown values, and every value at FCh.
- R3: At FEh, code-array (class 0) and fuse (class 1) writes are denied with status 03h, and reads of those classes are granted.
- R4: At FCh, code-array and fuse reads are denied with status 0Bh, and writes of those classes are denied with status 03h.
- R5: Block erase (kind 2) is granted only at FFh and is otherwise denied with 03h. Whole-array erase (kind 3) and blank check (kind 4) are granted at every level. These three kinds ignore the class.
- R6: Configuration bytes (class 3) selected by `req_sel` can be read and written at every level. Select 0 is boot status, select 1 is boot vector and select 2 is the extra byte. A write lands on `cfg_bytes_o[8*sel +: 8]`, and a read returns the byte on `rsp_rdata`.
- R7: Identification bytes (class 4) are granted for reads at every level. Writes to them are denied with status 03h.
- R8: A granted whole-array erase sets the level to FFh and sets the boot-status and boot-vector bytes to FFh in the same edge. The extra byte is left as it was.
- R9: Each request with `req_valid` high produces exactly one response one clock later on `rsp_valid`. `rsp_status` is 00h exactly when `rsp_grant` is 1. `rsp_rdata` is 00h except for granted protection-byte and configuration reads.
- R10: A kind above 4, a class above 4 for kinds 0 and 1, or a configuration select of 3 or more is denied with status 0Eh and changes no state.
- R11: A synchronous active-low reset sets the level and all configuration bytes to FFh and clears `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, at most one request per cycle |
| req_kind | input | 3 | Operation kind: 0 read, 1 write, 2 block erase, 3 whole-array erase, 4 blank check |
| req_class | input | 3 | Target: 0 code array, 1 fuse, 2 protection byte, 3 configuration, 4 identification |
| req_sel | input | SEL_W (2) | Configuration byte select |
| req_wdata | input | 8 | New level or configuration value for writes |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_grant | output | 1 | 1 when the request may proceed |
| rsp_status | output | 8 | 00h on grant, otherwise 03h, 0Bh or 0Eh |
| rsp_rdata | output | 8 | Level or configuration byte for granted reads |
| sec_level_o | output | 8 | Current protection level |
| cfg_bytes_o | output | NUM_CFG*8 (24) | Configuration bytes, select 0 in the low byte |

## Verification
The bench walks the level up in two ways: in two steps (FFh, FEh, FCh) and in one jump (FFh to FCh). At each level it sends the same mix of code-array, fuse, erase and configuration requests, so each rule can be tied to the level that produced it. Protection-byte writes are tried with stricter, equal, relaxing and unknown values, which separates a true one-way ratchet from a plain comparator or a write-once flag. Back-to-back requests with mixed kinds test that each response pairs with its own request. Whole-array erases at the strictest level, with the extra byte holding a non-erased value, show which bytes the erase restores and which it leaves alone.

// File: rtl/sec_gate_pkg.sv
// Shared encodings for the security level gate: operation kinds, target
// classes, level codes, status codes and the decision record.
// Assumes byte-wide level and configuration storage.
package sec_gate_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_READ       = 3'd0,
        OP_WRITE      = 3'd1,
        OP_BLK_ERASE  = 3'd2,
        OP_CHIP_ERASE = 3'd3,
        OP_BLANK_CHK  = 3'd4
    } op_kind_e;

    typedef enum logic [2:0] {
        TGT_ARRAY   = 3'd0,
        TGT_FUSE    = 3'd1,
        TGT_PROT    = 3'd2,
        TGT_CFG     = 3'd3,
        TGT_IDENT   = 3'd4
    } tgt_class_e;

    localparam logic [BYTE_W-1:0] LVL_OPEN   = 8'hFF;
    localparam logic [BYTE_W-1:0] LVL_WPROT  = 8'hFE;
    localparam logic [BYTE_W-1:0] LVL_RWPROT = 8'hFC;
    localparam logic [BYTE_W-1:0] ERASED_VAL = 8'hFF;

    localparam logic [BYTE_W-1:0] ST_OK        = 8'h00;
    localparam logic [BYTE_W-1:0] ST_WRITE_ERR = 8'h03;
    localparam logic [BYTE_W-1:0] ST_VENDOR    = 8'h0B;
    localparam logic [BYTE_W-1:0] ST_UNKNOWN   = 8'h0E;

    typedef struct packed {
        logic              grant;
        logic [BYTE_W-1:0] status;
        logic              lvl_wr;
        logic              cfg_wr;
        logic              chip_erase;
    } decision_t;

    // Strictness rank of a level code: 0 open, 1 write, 2 full, 3 illegal.
    function automatic logic [1:0] lvl_rank(input logic [BYTE_W-1:0] code);
        case (code)
            LVL_OPEN:   lvl_rank = 2'd0;
            LVL_WPROT:  lvl_rank = 2'd1;
            LVL_RWPROT: lvl_rank = 2'd2;
            default:    lvl_rank = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/sec_level_reg.sv
// Protection level register. Holds the level byte; loads a new value on
// a write strobe and returns to the open code on reset or erase strobe.
// Assumes the caller only strobes writes of legal, stricter codes.
module sec_level_reg
    import sec_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_val,
    input  logic              clr,
    output logic [BYTE_W-1:0] level_o
);

    logic [BYTE_W-1:0] level_q;

    // Level storage: reset and erase reopen, write ratchets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= LVL_OPEN;
        end else if (clr) begin
            level_q <= LVL_OPEN;
        end else if (wr_en) begin
            level_q <= wr_val;
        end
    end

    assign level_o = level_q;

endmodule

// File: rtl/sec_cfg_bank.sv
// Bank of configuration bytes. Each byte is written when selected; bytes
// flagged in CLR_MASK return to the erased value on the erase strobe.
// Assumes sel is in range whenever wr_en is high.
module sec_cfg_bank
    import sec_gate_pkg::*;
#(
    parameter int                 NUM_CFG  = 3,
    parameter int                 SEL_W    = 2,
    parameter logic [NUM_CFG-1:0] CLR_MASK = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          sel,
    input  logic [BYTE_W-1:0]         wdata,
    input  logic                      clr,
    output logic [NUM_CFG*BYTE_W-1:0] cfg_o
);

    for (genvar i = 0; i < NUM_CFG; i++) begin : g_byte
        localparam bit CLR_ON_ERASE = CLR_MASK[i];
        logic [BYTE_W-1:0] byte_q;

        // One configuration byte: reset, optional erase, selected write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= ERASED_VAL;
            end else if (clr && CLR_ON_ERASE) begin
                byte_q <= ERASED_VAL;
            end else if (wr_en && (int'(sel) == i)) begin
                byte_q <= wdata;
            end
        end

        assign cfg_o[i*BYTE_W +: BYTE_W] = byte_q;
    end

endmodule

// File: rtl/sec_access_policy.sv
// Combinational access policy. Maps request kind, class, select, write
// value and current level onto a grant/deny decision with status code
// and the state-update strobes. Does not look at the request strobe.
module sec_access_policy
    import sec_gate_pkg::*;
#(
    parameter int NUM_CFG = 3,
    parameter int SEL_W   = 2
) (
    input  logic [2:0]        kind,
    input  logic [2:0]        tclass,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] level,
    output decision_t         dec
);

    logic sel_ok;
    logic raise_ok;
    logic is_open;
    logic is_full;

    // Helper terms: select range, legal stricter level, current level class.
    always_comb begin
        sel_ok   = (int'(sel) < NUM_CFG);
        raise_ok = (lvl_rank(wdata) != 2'd3) && (lvl_rank(wdata) > lvl_rank(level));
        is_open  = (level == LVL_OPEN);
        is_full  = (level == LVL_RWPROT);
    end

    // Decision table over kind, then class.
    always_comb begin
        dec = '{grant: 1'b0, status: ST_UNKNOWN, lvl_wr: 1'b0,
                cfg_wr: 1'b0, chip_erase: 1'b0};
        case (op_kind_e'(kind))
            OP_READ: begin
                case (tgt_class_e'(tclass))
                    TGT_ARRAY, TGT_FUSE: begin
                        dec.grant  = !is_full;
                        dec.status = is_full ? ST_VENDOR : ST_OK;
                    end
                    TGT_PROT, TGT_IDENT: begin
                        dec.grant  = 1'b1;
                        dec.status = ST_OK;
                    end
                    TGT_CFG: begin
                        dec.grant  = sel_ok;
                        dec.status = sel_ok ? ST_OK : ST_UNKNOWN;
                    end
                    default: ;
                endcase
            end
            OP_WRITE: begin
                case (tgt_class_e'(tclass))
                    TGT_ARRAY, TGT_FUSE: begin
                        dec.grant  = is_open;
                        dec.status = is_open ? ST_OK : ST_WRITE_ERR;
                    end
                    TGT_PROT: begin
                        dec.grant  = raise_ok;
                        dec.lvl_wr = raise_ok;
                        dec.status = raise_ok ? ST_OK : ST_WRITE_ERR;
                    end
                    TGT_CFG: begin
                        dec.grant  = sel_ok;
                        dec.cfg_wr = sel_ok;
                        dec.status = sel_ok ? ST_OK : ST_UNKNOWN;
                    end
                    TGT_IDENT: begin
                        dec.status = ST_WRITE_ERR;
                    end
                    default: ;
                endcase
            end
            OP_BLK_ERASE: begin
                dec.grant  = is_open;
                dec.status = is_open ? ST_OK : ST_WRITE_ERR;
            end
            OP_CHIP_ERASE: begin
                dec.grant      = 1'b1;
                dec.status     = ST_OK;
                dec.chip_erase = 1'b1;
            end
            OP_BLANK_CHK: begin
                dec.grant  = 1'b1;
                dec.status = ST_OK;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sec_level_gate.sv
// Top of the security level gate. Evaluates each strobed request against
// the policy, applies level / configuration / erase updates on the same
// edge, and registers grant, status and read data one cycle later.
// Assumes at most one request per cycle; requests need no back-pressure.
module sec_level_gate
    import sec_gate_pkg::*;
#(
    parameter int NUM_CFG = 3,
    parameter int SEL_W   = 2,
    parameter int NUM_CLR = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [2:0]                req_kind,
    input  logic [2:0]                req_class,
    input  logic [SEL_W-1:0]          req_sel,
    input  logic [BYTE_W-1:0]         req_wdata,
    output logic                      rsp_valid,
    output logic                      rsp_grant,
    output logic [BYTE_W-1:0]         rsp_status,
    output logic [BYTE_W-1:0]         rsp_rdata,
    output logic [BYTE_W-1:0]         sec_level_o,
    output logic [NUM_CFG*BYTE_W-1:0] cfg_bytes_o
);

    localparam logic [NUM_CFG-1:0] CLR_MASK = NUM_CFG'((1 << NUM_CLR) - 1);

    decision_t         dec;
    logic              lvl_wr;
    logic              cfg_wr;
    logic              erase;
    logic [BYTE_W-1:0] rd_next;
    logic [BYTE_W-1:0] cfg_pick;

    sec_access_policy #(.NUM_CFG(NUM_CFG), .SEL_W(SEL_W)) u_policy (
        .kind   (req_kind),
        .tclass (req_class),
        .sel    (req_sel),
        .wdata  (req_wdata),
        .level  (sec_level_o),
        .dec    (dec)
    );

    // Qualify update strobes with the request strobe.
    always_comb begin
        lvl_wr = req_valid && dec.lvl_wr;
        cfg_wr = req_valid && dec.cfg_wr;
        erase  = req_valid && dec.chip_erase;
    end

    sec_level_reg u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lvl_wr),
        .wr_val  (req_wdata),
        .clr     (erase),
        .level_o (sec_level_o)
    );

    sec_cfg_bank #(.NUM_CFG(NUM_CFG), .SEL_W(SEL_W), .CLR_MASK(CLR_MASK)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .sel   (req_sel),
        .wdata (req_wdata),
        .clr   (erase),
        .cfg_o (cfg_bytes_o)
    );

    // Select the configuration byte addressed by the request.
    always_comb begin
        cfg_pick = '0;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (int'(req_sel) == i) cfg_pick = cfg_bytes_o[i*BYTE_W +: BYTE_W];
        end
    end

    // Read data for granted protection-byte and configuration reads only.
    always_comb begin
        rd_next = '0;
        if (dec.grant && (req_kind == OP_READ)) begin
            if (req_class == TGT_PROT)     rd_next = sec_level_o;
            else if (req_class == TGT_CFG) rd_next = cfg_pick;
        end
    end

    // Response registers: one response per request, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_grant  <= 1'b0;
            rsp_status <= ST_OK;
            rsp_rdata  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_grant  <= dec.grant;
                rsp_status <= dec.status;
                rsp_rdata  <= rd_next;
            end
        end
    end

endmodule

// File: rtl/sec_level_gate_chk.sv
// Property checker for the security level gate, attached by bind.
// Observes only the top-level ports.
module sec_level_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  req_kind,
    input logic [2:0]  req_class,
    input logic        rsp_valid,
    input logic        rsp_grant,
    input logic [7:0]  rsp_status,
    input logic [7:0]  sec_level_o,
    input logic [15:0] cfg_lo
);

    AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_level_o == 8'hFF) || (sec_level_o == 8'hFE) || (sec_level_o == 8'hFC)); // R1

    AST_LEVEL_NO_RELAX: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(req_valid && (req_kind == 3'd3))
        |-> sec_level_o <= $past(sec_level_o)); // R2

    AST_WPROT_WRITE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_kind == 3'd1) && (req_class <= 3'd1) && (sec_level_o == 8'hFE)
        |=> !rsp_grant && (rsp_status == 8'h03)); // R3

    AST_FULL_READ_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_kind == 3'd0) && (req_class <= 3'd1) && (sec_level_o == 8'hFC)
        |=> !rsp_grant && (rsp_status == 8'h0B)); // R4

    AST_BLK_ERASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_kind == 3'd2) && (sec_level_o != 8'hFF)
        |=> !rsp_grant && (rsp_status == 8'h03)); // R5

    AST_IDENT_WRITE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_kind == 3'd1) && (req_class == 3'd4)
        |=> !rsp_grant && (rsp_status == 8'h03)); // R7

    AST_ERASE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_kind == 3'd3)
        |=> rsp_grant && (sec_level_o == 8'hFF) && (cfg_lo == 16'hFFFF)); // R8

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R9

    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R9

    AST_GRANT_MATCHES_OK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant == (rsp_status == 8'h00))); // R9

endmodule

bind sec_level_gate sec_level_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_class   (req_class),
    .rsp_valid   (rsp_valid),
    .rsp_grant   (rsp_grant),
    .rsp_status  (rsp_status),
    .sec_level_o (sec_level_o),
    .cfg_lo      (cfg_bytes_o[15:0])
);

// File: tb/sec_level_gate_tb_top.sv
// Scoreboard bench: the driver task computes expected responses from the
// requirements and queues them; the monitor pops and compares responses.
module sec_level_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [2:0]  req_class = '0;
    logic [1:0]  req_sel = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_grant;
    logic [7:0]  rsp_status;
    logic [7:0]  rsp_rdata;
    logic [7:0]  sec_level_o;
    logic [23:0] cfg_bytes_o;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic       grant;
        logic [7:0] status;
        logic [7:0] rdata;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    logic [7:0] m_lvl;
    logic [7:0] m_cfg [3];

    always #4 clk = ~clk;

    sec_level_gate dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_class   (req_class),
        .req_sel     (req_sel),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_grant   (rsp_grant),
        .rsp_status  (rsp_status),
        .rsp_rdata   (rsp_rdata),
        .sec_level_o (sec_level_o),
        .cfg_bytes_o (cfg_bytes_o)
    );

    function automatic int rank(input logic [7:0] c);
        if (c == 8'hFF) return 0;
        if (c == 8'hFE) return 1;
        if (c == 8'hFC) return 2;
        return 3;
    endfunction

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Driver: compute expectation from the requirement model, queue, drive.
    task automatic send(input logic [2:0] k, input logic [2:0] c, input logic [1:0] s,
                        input logic [7:0] w, input string tag);
        exp_t e;
        e.grant = 1'b0; e.status = 8'h0E; e.rdata = 8'h00; e.tag = tag;
        case (k)
            3'd0: case (c)
                3'd0, 3'd1: begin e.grant = (m_lvl != 8'hFC); e.status = e.grant ? 8'h00 : 8'h0B; end
                3'd2: begin e.grant = 1; e.status = 0; e.rdata = m_lvl; end
                3'd3: if (s < 3) begin e.grant = 1; e.status = 0; e.rdata = m_cfg[s]; end
                3'd4: begin e.grant = 1; e.status = 0; end
                default: ;
            endcase
            3'd1: case (c)
                3'd0, 3'd1: begin e.grant = (m_lvl == 8'hFF); e.status = e.grant ? 8'h00 : 8'h03; end
                3'd2: begin
                    e.grant = (rank(w) != 3) && (rank(w) > rank(m_lvl));
                    e.status = e.grant ? 8'h00 : 8'h03;
                    if (e.grant) m_lvl = w;
                end
                3'd3: if (s < 3) begin e.grant = 1; e.status = 0; m_cfg[s] = w; end
                3'd4: e.status = 8'h03;
                default: ;
            endcase
            3'd2: begin e.grant = (m_lvl == 8'hFF); e.status = e.grant ? 8'h00 : 8'h03; end
            3'd3: begin e.grant = 1; e.status = 0; m_lvl = 8'hFF; m_cfg[0] = 8'hFF; m_cfg[1] = 8'hFF; end
            3'd4: begin e.grant = 1; e.status = 0; end
            default: ;
        endcase
        exp_q.push_back(e);
        req_valid = 1'b1; req_kind = k; req_class = c; req_sel = s; req_wdata = w;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: every response must match the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t e;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9 unexpected response actual grant=%0b expected none", rsp_grant);
            end else begin
                e = exp_q.pop_front();
                if (rsp_grant !== e.grant || rsp_status !== e.status || rsp_rdata !== e.rdata) begin
                    n_fail++;
                    $display("FAIL %s actual grant=%0b st=%02h rd=%02h expected grant=%0b st=%02h rd=%02h",
                             e.tag, rsp_grant, rsp_status, rsp_rdata, e.grant, e.status, e.rdata);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        m_lvl = 8'hFF;
        for (int i = 0; i < 3; i++) m_cfg[i] = 8'hFF;
        repeat (3) @(negedge clk);
        chk8("R11 rsp_valid in reset", {7'd0, rsp_valid}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk8("R11 level after reset", sec_level_o, 8'hFF);
        chk8("R11 cfg0 after reset", cfg_bytes_o[7:0], 8'hFF);
        chk8("R11 cfg1 after reset", cfg_bytes_o[15:8], 8'hFF);
        chk8("R11 cfg2 after reset", cfg_bytes_o[23:16], 8'hFF);

        // Open level, back-to-back mix.
        send(0, 0, 0, 0, "R3 array read at FF");
        send(1, 0, 0, 0, "R3 array write at FF");
        send(1, 1, 0, 0, "R3 fuse write at FF");
        send(2, 5, 0, 0, "R5 block erase at FF");
        send(0, 4, 0, 0, "R7 ident read at FF");
        send(1, 4, 0, 0, "R7 ident write at FF");
        send(1, 3, 0, 8'h12, "R6 cfg0 write");
        send(1, 3, 1, 8'h34, "R6 cfg1 write");
        send(1, 3, 2, 8'h56, "R6 cfg2 write");
        send(0, 3, 1, 0, "R6 cfg1 read");
        send(6, 0, 0, 0, "R10 bad kind");
        send(1, 3, 3, 8'h99, "R10 bad select write");
        send(0, 5, 0, 0, "R10 bad class read");
        send(1, 2, 0, 8'h80, "R2 unknown level code");
        send(1, 2, 0, 8'hFF, "R2 equal level code");
        idle(1);
        chk8("R6 cfg0 value", cfg_bytes_o[7:0], 8'h12);
        chk8("R6 cfg2 value", cfg_bytes_o[23:16], 8'h56);
        chk8("R10 level unchanged", sec_level_o, 8'hFF);

        // Write-protected level.
        send(1, 2, 0, 8'hFE, "R2 raise to FE");
        send(1, 0, 0, 0, "R3 array write at FE");
        send(1, 1, 0, 0, "R3 fuse write at FE");
        send(0, 0, 0, 0, "R3 array read at FE");
        send(0, 1, 0, 0, "R3 fuse read at FE");
        send(2, 0, 0, 0, "R5 block erase at FE");
        send(4, 0, 0, 0, "R5 blank check at FE");
        send(1, 2, 0, 8'hFF, "R2 relax to FF");
        send(1, 3, 0, 8'h77, "R6 cfg0 write at FE");
        idle(1);
        chk8("R2 level FE", sec_level_o, 8'hFE);

        // Fully protected level.
        send(1, 2, 0, 8'hFC, "R2 raise to FC");
        send(0, 0, 0, 0, "R4 array read at FC");
        send(0, 1, 0, 0, "R4 fuse read at FC");
        send(1, 0, 0, 0, "R4 array write at FC");
        send(1, 1, 0, 0, "R4 fuse write at FC");
        send(1, 2, 0, 8'hFE, "R2 relax to FE at FC");
        send(1, 2, 0, 8'hFC, "R2 equal at FC");
        send(0, 2, 0, 0, "R1 level read at FC");
        send(0, 3, 0, 0, "R6 cfg0 read at FC");
        send(0, 4, 0, 0, "R7 ident read at FC");
        send(2, 0, 0, 0, "R5 block erase at FC");
        send(4, 0, 0, 0, "R5 blank check at FC");
        idle(1);
        chk8("R2 level FC", sec_level_o, 8'hFC);
        send(3, 0, 0, 0, "R8 full erase at FC");
        idle(1);
        chk8("R8 level restored", sec_level_o, 8'hFF);
        chk8("R8 boot status restored", cfg_bytes_o[7:0], 8'hFF);
        chk8("R8 boot vector restored", cfg_bytes_o[15:8], 8'hFF);
        chk8("R8 extra byte kept", cfg_bytes_o[23:16], 8'h56);
        chk8("R9 no response when idle", {7'd0, rsp_valid}, 8'h00);

        // Single jump to the strictest level, then erase again.
        send(1, 2, 0, 8'hFC, "R2 jump FF to FC");
        send(0, 2, 0, 0, "R1 level read after jump");
        send(3, 2, 0, 0, "R8 second full erase");
        send(0, 2, 0, 0, "R1 level read after erase");
        idle(2);

        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 missing responses actual=%0d expected=0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule